// File: doc/BRIEF.md
# Factory Bad Block Scanner

This block runs once after reset and sorts every erase block of a raw NAND array into good or bad according to the factory marking. For each block it issues single-byte read requests on a simple page-read port that sits in front of a command sequencer. Each request asks for the first byte of the spare area, at column 2048, of page 0 and, when needed, of page 1. A block whose marker byte is anything other than FFh on either page is recorded as bad. Block 0 is guaranteed valid, so it is recorded as good without being read. Only reads are ever issued, so a marked block is never erased or programmed by this block.

Results go into a one-bit-per-block bitmap. Other logic can query the bitmap through a read port with one cycle of latency. When the last block has been recorded, the block raises a sticky done flag and holds the number of bad blocks. It also raises a fault flag when that number is greater than the allowed maximum (80 by default, since at least 4,016 of the 4,096 blocks must be valid).

The controller is a seven-state machine:
- ST_TRUST0 records block 0 as good and moves to ST_ASK_P0.
- ST_ASK_P0 presents the page-0 request and moves to ST_WAIT_P0 on acceptance.
- ST_WAIT_P0 takes the response. A non-FFh byte goes straight to ST_RECORD and skips page 1. FFh goes to ST_ASK_P1.
- ST_ASK_P1 presents the page-1 request and moves to ST_WAIT_P1 on acceptance.
- ST_WAIT_P1 takes the response and moves to ST_RECORD.
- ST_RECORD writes the bitmap and bumps the count. It goes to ST_DONE after the last block, otherwise to ST_ASK_P0 for the next block.
- ST_DONE is terminal until the next reset.

Top module: `bad_block_scanner`

## Requirements
- R1: While reset is held, and in the first cycle after its release, done is 0, fault is 0, bad_count is 0 and busy is 1.
- R2: Every read request carries rd_req_col = 2048 and rd_req_row = block × PAGES + page, with page 0 or 1. PAGES is a power of two.
- R3: No read request ever targets block 0, and block 0 is reported good (query_bad = 0) whatever its markers hold.
- R4: A block other than block 0 is reported bad (query_bad = 1) exactly when its page-0 marker or its page-1 marker is not FFh.
- R5: When the page-0 marker of a block is not FFh, no request is issued for page 1 of that block.
- R6: A request that is not accepted (rd_req_valid = 1, rd_req_ready = 0) stays valid with an unchanged row in the next cycle.
- R7: Blocks are visited in ascending order from block 1, each exactly once, with page 0 before page 1.
- R8: After the last block is recorded, done goes to 1 and stays 1, bad_count equals the number of bad blocks, and no further requests are issued.
- R9: fault is 1 exactly when done is 1 and bad_count is greater than MAX_BAD.
- R10: query_bad shows the recorded status of the block on query_blk one clock edge after query_blk is applied.
- R11: At most one read is outstanding. After a request is accepted, no new request is presented until rd_rsp_valid returns its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; a scan starts on its release |
| rd_req_valid | output | 1 | A single-byte read request is presented |
| rd_req_ready | input | 1 | The sequencer accepts the request in this cycle |
| rd_req_row | output | ROW_W | Row (page) address: block × PAGES + page |
| rd_req_col | output | COL_W | Column address of the byte, always the first spare byte |
| rd_rsp_valid | input | 1 | The byte of the outstanding read is on rd_rsp_data |
| rd_rsp_data | input | 8 | Marker byte returned by the read |
| busy | output | 1 | The scan is in progress |
| done | output | 1 | All blocks are recorded (sticky until reset) |
| bad_count | output | CNT_W | Number of blocks recorded bad |
| fault | output | 1 | Done, with more bad blocks than MAX_BAD |
| query_blk | input | BLK_W | Block whose status is looked up |
| query_bad | output | 1 | Status of the queried block, one cycle later; 1 = bad |

## Verification
The bench builds the block with 40 blocks of 8 pages and MAX_BAD = 6. This keeps a whole scan within a few hundred cycles, so many scans can run, each after a fresh reset. The small MAX_BAD puts both sides of the fault threshold within reach of directed patterns with exactly 6 and exactly 7 bad blocks. The small block count lets every bitmap entry be queried after each scan. The bench also randomizes accept stalls, response latency and marker values, and it places bad markers on block 0 and on page 1 only. These cover the skip, hold and trust rules.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [2:0] {
        ST_TRUST0,
        ST_ASK_P0,
        ST_WAIT_P0,
        ST_ASK_P1,
        ST_WAIT_P1,
        ST_RECORD,
        ST_DONE
    } scan_state_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
    parameter int DEPTH = 4096,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bad,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bad
);

    logic mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_bad;
        end
        rd_bad <= mem[rd_addr];
    end

endmodule

// File: rtl/bbs_fsm.sv
module bbs_fsm
    import bbs_pkg::*;
#(
    parameter int NUM_BLOCKS = 4096,
    parameter int PAGES      = 64,
    parameter int COL_W      = 12,
    parameter int SPARE_COL  = 2048,
    parameter int MAX_BAD    = 80,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int PG_W      = $clog2(PAGES),
    localparam int ROW_W     = BLK_W + PG_W,
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [ROW_W-1:0] rd_req_row,
    output logic [COL_W-1:0] rd_req_col,
    input  logic             rd_rsp_valid,
    input  logic [7:0]       rd_rsp_data,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] bad_count,
    output logic             fault,
    output logic             bm_we,
    output logic [BLK_W-1:0] bm_addr,
    output logic             bm_bad
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_t      state, nxt;
    logic [BLK_W-1:0] blk;
    logic             cur_bad;
    logic             last_blk;

    assign last_blk = (blk == LAST_BLK);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_TRUST0;
        end else begin
            state <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_TRUST0:  nxt = (NUM_BLOCKS > 1) ? ST_ASK_P0 : ST_DONE;
            ST_ASK_P0:  if (rd_req_ready) nxt = ST_WAIT_P0;
            ST_WAIT_P0: if (rd_rsp_valid)
                            nxt = (rd_rsp_data != ERASED_BYTE) ? ST_RECORD : ST_ASK_P1;
            ST_ASK_P1:  if (rd_req_ready) nxt = ST_WAIT_P1;
            ST_WAIT_P1: if (rd_rsp_valid) nxt = ST_RECORD;
            ST_RECORD:  nxt = last_blk ? ST_DONE : ST_ASK_P0;
            ST_DONE:    nxt = ST_DONE;
            default:    nxt = ST_TRUST0;
        endcase
    end

    // block pointer, verdict and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk       <= '0;
            cur_bad   <= 1'b0;
            bad_count <= '0;
        end else begin
            unique case (state)
                ST_TRUST0: begin
                    if (NUM_BLOCKS > 1) blk <= BLK_W'(1);
                end
                ST_WAIT_P0, ST_WAIT_P1: begin
                    if (rd_rsp_valid) cur_bad <= (rd_rsp_data != ERASED_BYTE);
                end
                ST_RECORD: begin
                    if (cur_bad) bad_count <= bad_count + CNT_W'(1);
                    if (!last_blk) blk <= blk + BLK_W'(1);
                    cur_bad <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_req_valid = (state == ST_ASK_P0) || (state == ST_ASK_P1);
        rd_req_row   = {blk, PG_W'(state == ST_ASK_P1)};
        rd_req_col   = COL_W'(SPARE_COL);
        busy         = (state != ST_DONE);
        done         = (state == ST_DONE);
        fault        = done && (bad_count > CNT_W'(MAX_BAD));
        bm_we        = (state == ST_TRUST0) || (state == ST_RECORD);
        bm_addr      = (state == ST_TRUST0) ? '0 : blk;
        bm_bad       = (state == ST_RECORD) && cur_bad;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_row))); // R6

    AST_NO_BLK0_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_row >= ROW_W'(PAGES))); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !rd_req_valid && $stable(bad_count))); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bad_count == $past(bad_count)) ||
                  (bad_count == $past(bad_count) + CNT_W'(1)))); // R8

    AST_FAULT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done); // R9

endmodule

// File: rtl/bad_block_scanner.sv
module bad_block_scanner #(
    parameter int NUM_BLOCKS = 4096,
    parameter int PAGES      = 64,
    parameter int COL_W      = 12,
    parameter int SPARE_COL  = 2048,
    parameter int MAX_BAD    = 80,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int PG_W      = $clog2(PAGES),
    localparam int ROW_W     = BLK_W + PG_W,
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [ROW_W-1:0] rd_req_row,
    output logic [COL_W-1:0] rd_req_col,
    input  logic             rd_rsp_valid,
    input  logic [7:0]       rd_rsp_data,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] bad_count,
    output logic             fault,
    input  logic [BLK_W-1:0] query_blk,
    output logic             query_bad
);

    logic             bm_we;
    logic [BLK_W-1:0] bm_addr;
    logic             bm_bad;

    bbs_fsm #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .PAGES      (PAGES),
        .COL_W      (COL_W),
        .SPARE_COL  (SPARE_COL),
        .MAX_BAD    (MAX_BAD)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_row   (rd_req_row),
        .rd_req_col   (rd_req_col),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .busy         (busy),
        .done         (done),
        .bad_count    (bad_count),
        .fault        (fault),
        .bm_we        (bm_we),
        .bm_addr      (bm_addr),
        .bm_bad       (bm_bad)
    );

    bbs_bitmap #(
        .DEPTH (NUM_BLOCKS),
        .AW    (BLK_W)
    ) u_bitmap (
        .clk     (clk),
        .wr_en   (bm_we),
        .wr_addr (bm_addr),
        .wr_bad  (bm_bad),
        .rd_addr (query_blk),
        .rd_bad  (query_bad)
    );

endmodule

// File: tb/tb_bad_block_scanner.sv
module tb_bad_block_scanner;

    localparam int NB      = 40;
    localparam int PG      = 8;
    localparam int COLW    = 12;
    localparam int SPARE   = 2048;
    localparam int MAXB    = 6;
    localparam int BLK_W   = $clog2(NB);
    localparam int ROW_W   = BLK_W + $clog2(PG);
    localparam int CNT_W   = $clog2(NB + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_req_valid;
    logic             rd_req_ready = 1'b0;
    logic [ROW_W-1:0] rd_req_row;
    logic [COLW-1:0]  rd_req_col;
    logic             rd_rsp_valid = 1'b0;
    logic [7:0]       rd_rsp_data = 8'h00;
    logic             busy, done, fault, query_bad;
    logic [CNT_W-1:0] bad_count;
    logic [BLK_W-1:0] query_blk = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] m0 [NB];
    logic [7:0] m1 [NB];

    always #10 clk = ~clk;

    bad_block_scanner #(
        .NUM_BLOCKS (NB), .PAGES (PG), .COL_W (COLW),
        .SPARE_COL (SPARE), .MAX_BAD (MAXB)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .rd_req_valid (rd_req_valid), .rd_req_ready (rd_req_ready),
        .rd_req_row (rd_req_row), .rd_req_col (rd_req_col),
        .rd_rsp_valid (rd_rsp_valid), .rd_rsp_data (rd_rsp_data),
        .busy (busy), .done (done), .bad_count (bad_count), .fault (fault),
        .query_blk (query_blk), .query_bad (query_bad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bad(input int b);
        return (b != 0) && ((m0[b] != 8'hFF) || (m1[b] != 8'hFF));
    endfunction

    function automatic int exp_count();
        int c = 0;
        for (int b = 0; b < NB; b++) if (exp_bad(b)) c++;
        return c;
    endfunction

    function automatic int exp_reqs();
        int c = 0;
        for (int b = 1; b < NB; b++) c += (m0[b] != 8'hFF) ? 1 : 2;
        return c;
    endfunction

    function automatic logic [7:0] bad_byte();
        logic [7:0] v;
        v = 8'($urandom % 255);
        return v;
    endfunction

    task automatic fill_all_good();
        for (int b = 0; b < NB; b++) begin m0[b] = 8'hFF; m1[b] = 8'hFF; end
    endtask

    task automatic run_scan(input string tag);
        bit pending = 0;
        int lat = 0;
        int cyc = 0;
        int nreq = 0;
        int exp_blk = 1;
        int exp_pg = 0;
        int acc_blk = 0;
        int acc_pg = 0;
        bit seq_ok = 1, col_ok = 1, out_ok = 1, hold_ok = 1, blk0_ok = 1;
        bit waiting_hold = 0;
        logic [ROW_W-1:0] held_row = '0;
        int first_bad_row = 0;

        rst_n = 1'b0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 0 && fault == 0 && bad_count == 0 && busy == 1,
            {"R1 reset state ", tag}, int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && bad_count == 0 && busy == 1,
            {"R1 after release ", tag}, int'(bad_count), 0);

        while (!done && cyc < 20000) begin
            rd_rsp_valid = 1'b0;
            rd_req_ready = 1'b0;
            if (waiting_hold) begin
                if (!rd_req_valid || rd_req_row != held_row) hold_ok = 0;
                waiting_hold = 0;
            end
            if (pending) begin
                if (rd_req_valid) out_ok = 0;
                if (lat == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = (acc_pg == 0) ? m0[acc_blk] : m1[acc_blk];
                    pending = 0;
                end else begin
                    lat--;
                end
            end else if (rd_req_valid) begin
                if (rd_req_col != COLW'(SPARE)) col_ok = 0;
                if (($urandom % 2) == 0) begin
                    rd_req_ready = 1'b1;
                    acc_blk = int'(rd_req_row) / PG;
                    acc_pg  = int'(rd_req_row) % PG;
                    if (acc_blk == 0) blk0_ok = 0;
                    if (acc_blk != exp_blk || acc_pg != exp_pg) begin
                        if (seq_ok) first_bad_row = int'(rd_req_row);
                        seq_ok = 0;
                    end
                    if (exp_pg == 0 && m0[exp_blk] == 8'hFF) exp_pg = 1;
                    else begin exp_pg = 0; exp_blk++; end
                    nreq++;
                    pending = 1;
                    lat = $urandom % 4;
                end else begin
                    waiting_hold = 1;
                    held_row = rd_req_row;
                end
            end
            @(negedge clk);
            cyc++;
        end
        rd_rsp_valid = 1'b0;
        rd_req_ready = 1'b0;

        chk(done == 1, {"R8 done reached ", tag}, int'(done), 1);
        chk(seq_ok, {"R2 R5 R7 request order/row ", tag}, first_bad_row, exp_blk * PG + exp_pg);
        chk(col_ok, {"R2 column is first spare byte ", tag}, int'(rd_req_col), SPARE);
        chk(blk0_ok, {"R3 block 0 never read ", tag}, int'(blk0_ok), 1);
        chk(nreq == exp_reqs(), {"R5 request count ", tag}, nreq, exp_reqs());
        chk(hold_ok, {"R6 stalled request held ", tag}, int'(hold_ok), 1);
        chk(out_ok, {"R11 one outstanding read ", tag}, int'(out_ok), 1);
        chk(int'(bad_count) == exp_count(), {"R8 bad count ", tag}, int'(bad_count), exp_count());
        chk(fault == (exp_count() > MAXB), {"R9 fault flag ", tag}, int'(fault), int'(exp_count() > MAXB));

        begin
            bit q_ok = 1;
            int q_blk = 0, q_act = 0, q_exp = 0;
            for (int b = 0; b < NB; b++) begin
                query_blk = BLK_W'(b);
                @(negedge clk);
                if (query_bad != exp_bad(b) && q_ok) begin
                    q_ok = 0; q_blk = b; q_act = int'(query_bad); q_exp = int'(exp_bad(b));
                end
            end
            chk(q_ok, {"R4 R10 bitmap query ", tag}, q_act, q_exp);
            if (!q_ok) $display("  first mismatching block %0d", q_blk);
            query_blk = '0;
            @(negedge clk);
            chk(query_bad == 1'b0, {"R3 block 0 reported good ", tag}, int'(query_bad), 0);
        end

        begin
            bit stay_ok = 1;
            int c0 = int'(bad_count);
            repeat (5) begin
                @(negedge clk);
                if (!done || rd_req_valid || int'(bad_count) != c0) stay_ok = 0;
            end
            chk(stay_ok, {"R8 done sticky, no more requests ", tag}, int'(done), 1);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int pick;
        void'($urandom(32'd20240611));

        fill_all_good();
        run_scan("all good");

        fill_all_good();
        m0[0] = 8'h00; m1[0] = 8'h12;
        for (int b = 1; b < NB; b++) begin
            if (($urandom % 16) == 0) m0[b] = bad_byte();
            if (($urandom % 16) == 0) m1[b] = bad_byte();
        end
        run_scan("sparse random, block0 marked");

        fill_all_good();
        for (int b = 1; b < NB; b += 3) m1[b] = 8'hFE;
        run_scan("page1-only bad, dense");

        fill_all_good();
        m0[1] = 8'h00; m1[5] = 8'h7F; m0[10] = 8'hFE; m1[10] = 8'h00;
        m1[20] = 8'h01; m0[30] = 8'h80; m0[NB-1] = 8'h00;
        run_scan("exactly MAX_BAD");

        m1[NB-2] = 8'hF0;
        run_scan("MAX_BAD plus one");

        for (int r = 0; r < 4; r++) begin
            fill_all_good();
            for (int b = 0; b < NB; b++) begin
                pick = $urandom % 8;
                if (pick == 0) m0[b] = bad_byte();
                else if (pick == 1) m1[b] = bad_byte();
                else if (pick == 2) begin m0[b] = bad_byte(); m1[b] = bad_byte(); end
            end
            run_scan($sformatf("random mix %0d", r));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule